// File: doc/BRIEF.md
# Masked BCD Calendar Alarm Comparator

This block watches a live calendar presented in BCD (seconds, minutes, hours with a PM bit, day of month and weekday) and compares it with a stored 32-bit alarm word once per seconds tick. Every field of the alarm word carries its own "don't care" bit, so an alarm can fire every minute, every hour, every day or on a chosen date or weekday. A match while the alarm is enabled sets a sticky flag. The flag raises an interrupt line when interrupts are enabled, and it stays set until software clears it.

The alarm word is protected against updates while the alarm is live. Software first clears the alarm enable. After a fixed number of clocks the block reports that writes are allowed. Software then loads the word and enables the alarm again, which closes the write window at once.

Top module: `bcd_alarm_match`

## Requirements
- R1: After reset, alarm_word is 0, alarm_en, irq_en, alarm_flag and alarm_irq are 0, and wr_allowed is 0.
- R2: Alarm word layout: seconds BCD in bits 6:0, minutes BCD in bits 14:8, hours BCD in bits 21:16 with PM in bit 22, day field in bits 29:24. When no field is masked, alarm_flag is set on a tick only if seconds, minutes, {PM, hours} and the day field all equal the calendar inputs.
- R3: Bit 7 masks seconds, bit 15 masks minutes and bit 23 masks hours together with PM. A masked field takes no part in the comparison.
- R4: Bit 30 selects weekday matching, in which bits 27:24 are compared with {0, cal_wday} and bits 29:28 are ignored. When bit 30 is 0, bits 29:24 are compared with cal_date. Bit 31 masks the whole day field, so the alarm fires on any date or weekday.
- R5: The comparison takes effect only in a cycle with sec_tick = 1 and alarm_en = 1. A match without a tick, or a tick while the alarm is disabled, leaves alarm_flag at 0.
- R6: alarm_flag stays 1 until a cycle with flag_clr = 1 clears it. If a firing tick and flag_clr occur in the same cycle, the flag is set.
- R7: alarm_irq is 1 exactly when alarm_flag = 1 and irq_en = 1.
- R8: wr_allowed goes to 0 at the clock edge that captures alarm_en = 1. It rises at the SYNC_CYCLES-th clock edge after the edge that captures alarm_en = 0; after reset, the count starts with the first edge.
- R9: A write to alarm_word (word_we) takes effect only when wr_allowed = 1 in that cycle. Otherwise it is ignored, and alarm_word keeps its value.
- R10: A match fires once per tick. After the flag is cleared while the calendar stays equal to the alarm, alarm_flag stays 0 until the next matching tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse marking a new calendar second |
| cal_sec | input | 7 | Calendar seconds, BCD |
| cal_min | input | 7 | Calendar minutes, BCD |
| cal_hour | input | 6 | Calendar hours, BCD |
| cal_pm | input | 1 | Calendar PM indicator |
| cal_date | input | 6 | Calendar day of month, BCD |
| cal_wday | input | 3 | Calendar weekday, 1 to 7 |
| ctrl_we | input | 1 | Load the two enable bits |
| ctrl_alarm_en | input | 1 | Alarm enable value to load |
| ctrl_irq_en | input | 1 | Interrupt enable value to load |
| word_we | input | 1 | Request to write the alarm word |
| word_wdata | input | 32 | Alarm word write data |
| flag_clr | input | 1 | Clear the alarm flag |
| alarm_word | output | 32 | Stored alarm word |
| alarm_en | output | 1 | Current alarm enable |
| irq_en | output | 1 | Current interrupt enable |
| wr_allowed | output | 1 | Alarm word may be written |
| alarm_flag | output | 1 | Sticky alarm event flag |
| alarm_irq | output | 1 | Interrupt request |

## Verification
The properties assume that sec_tick is a one-cycle strobe and that the calendar inputs do not change in the cycle in which it is high. They also assume that flag_clr is a one-cycle request, like a bus write. The stimulus changes calendar values only in cycles before a tick and drives every strobe for exactly one cycle, on the falling clock edge. Alarm word updates always follow the disable-and-wait sequence, with one deliberate write attempted while the alarm is enabled.

// File: rtl/bcd_alarm_pkg.sv
package bcd_alarm_pkg;
   // widest compared field: {PM, hour} and the day slot both fit
   localparam int FLD_W   = 7;
   localparam int NUM_FLD = 4;
   localparam int WORD_W  = 32;

   // alarm word bit positions (software-visible layout)
   localparam int SEC_LSB  = 0;
   localparam int SEC_DC   = 7;
   localparam int MIN_LSB  = 8;
   localparam int MIN_DC   = 15;
   localparam int HR_LSB   = 16;
   localparam int HR_PM    = 22;
   localparam int HR_DC    = 23;
   localparam int DAY_LSB  = 24;

   typedef enum int {
      FLD_SEC  = 0,
      FLD_MIN  = 1,
      FLD_HOUR = 2,
      FLD_DAY  = 3
   } fld_e;
endpackage

// File: rtl/bcd_alarm_field_cmp.sv
module bcd_alarm_field_cmp #(
   parameter int W = 7
) (
   input  logic [W-1:0] want,
   input  logic [W-1:0] have,
   input  logic         dont_care,
   output logic         hit
);
   if (W < 1) begin : g_bad_w
      $error("bcd_alarm_field_cmp: W must be at least 1");
   end

   always_comb begin
      hit = dont_care || (want == have);
   end
endmodule

// File: rtl/bcd_alarm_day_view.sv
module bcd_alarm_day_view
   import bcd_alarm_pkg::*;
(
   input  logic [7:0]       day_byte,
   input  logic [5:0]       cal_date,
   input  logic [2:0]       cal_wday,
   output logic [FLD_W-1:0] want,
   output logic [FLD_W-1:0] have,
   output logic             dont_care
);
   logic by_weekday;

   always_comb begin
      by_weekday = day_byte[6];
      dont_care  = day_byte[7];
      if (by_weekday) begin
         want = {{(FLD_W-4){1'b0}}, day_byte[3:0]};
         have = {{(FLD_W-3){1'b0}}, cal_wday};
      end else begin
         want = {{(FLD_W-6){1'b0}}, day_byte[5:0]};
         have = {{(FLD_W-6){1'b0}}, cal_date};
      end
   end
endmodule

// File: rtl/bcd_alarm_wr_gate.sv
module bcd_alarm_wr_gate #(
   parameter int SYNC_CYCLES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_next,
   output logic wr_ok
);
   localparam int CNT_W = $clog2(SYNC_CYCLES + 1);
   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(SYNC_CYCLES);

   if (SYNC_CYCLES < 1) begin : g_bad_sync
      $error("bcd_alarm_wr_gate: SYNC_CYCLES must be at least 1");
   end

   logic [CNT_W-1:0] settle_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ok      <= 1'b0;
         settle_cnt <= '0;
      end else if (en_next) begin
         wr_ok      <= 1'b0;
         settle_cnt <= '0;
      end else if (!wr_ok) begin
         if (settle_cnt == LIMIT) begin
            wr_ok <= 1'b1;
         end else begin
            settle_cnt <= settle_cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/bcd_alarm_flag.sv
module bcd_alarm_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   input  logic clr,
   output logic flag
);
   // a new event outranks a clear in the same cycle so it is never lost
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag <= 1'b0;
      end else if (fire) begin
         flag <= 1'b1;
      end else if (clr) begin
         flag <= 1'b0;
      end
   end
endmodule

// File: rtl/bcd_alarm_match.sv
module bcd_alarm_match
   import bcd_alarm_pkg::*;
#(
   parameter int SYNC_CYCLES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        sec_tick,
   input  logic [6:0]  cal_sec,
   input  logic [6:0]  cal_min,
   input  logic [5:0]  cal_hour,
   input  logic        cal_pm,
   input  logic [5:0]  cal_date,
   input  logic [2:0]  cal_wday,
   input  logic        ctrl_we,
   input  logic        ctrl_alarm_en,
   input  logic        ctrl_irq_en,
   input  logic        word_we,
   input  logic [31:0] word_wdata,
   input  logic        flag_clr,
   output logic [31:0] alarm_word,
   output logic        alarm_en,
   output logic        irq_en,
   output logic        wr_allowed,
   output logic        alarm_flag,
   output logic        alarm_irq
);
   if (WORD_W != 32) begin : g_bad_word
      $error("bcd_alarm_match: alarm word must be 32 bits");
   end

   logic                en_next;
   logic [FLD_W-1:0]    want_v [NUM_FLD];
   logic [FLD_W-1:0]    have_v [NUM_FLD];
   logic [NUM_FLD-1:0]  dc_v;
   logic [NUM_FLD-1:0]  hit_v;
   logic                fire;

   // ---------------- control and word storage ----------------
   always_comb begin
      en_next = ctrl_we ? ctrl_alarm_en : alarm_en;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alarm_en <= 1'b0;
         irq_en   <= 1'b0;
      end else if (ctrl_we) begin
         alarm_en <= ctrl_alarm_en;
         irq_en   <= ctrl_irq_en;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alarm_word <= '0;
      end else if (word_we && wr_allowed) begin
         alarm_word <= word_wdata;
      end
   end

   bcd_alarm_wr_gate #(
      .SYNC_CYCLES (SYNC_CYCLES)
   ) u_wr_gate (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_next (en_next),
      .wr_ok   (wr_allowed)
   );

   // ---------------- field extraction ----------------
   always_comb begin
      want_v[FLD_SEC]  = alarm_word[SEC_LSB +: 7];
      have_v[FLD_SEC]  = cal_sec;
      dc_v[FLD_SEC]    = alarm_word[SEC_DC];
      want_v[FLD_MIN]  = alarm_word[MIN_LSB +: 7];
      have_v[FLD_MIN]  = cal_min;
      dc_v[FLD_MIN]    = alarm_word[MIN_DC];
      want_v[FLD_HOUR] = {alarm_word[HR_PM], alarm_word[HR_LSB +: 6]};
      have_v[FLD_HOUR] = {cal_pm, cal_hour};
      dc_v[FLD_HOUR]   = alarm_word[HR_DC];
   end

   bcd_alarm_day_view u_day_view (
      .day_byte  (alarm_word[DAY_LSB +: 8]),
      .cal_date  (cal_date),
      .cal_wday  (cal_wday),
      .want      (want_v[FLD_DAY]),
      .have      (have_v[FLD_DAY]),
      .dont_care (dc_v[FLD_DAY])
   );

   // ---------------- per-field comparators ----------------
   for (genvar g = 0; g < NUM_FLD; g++) begin : g_field
      bcd_alarm_field_cmp #(
         .W (FLD_W)
      ) u_cmp (
         .want      (want_v[g]),
         .have      (have_v[g]),
         .dont_care (dc_v[g]),
         .hit       (hit_v[g])
      );
   end

   always_comb begin
      fire = sec_tick && alarm_en && (&hit_v);
   end

   bcd_alarm_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .fire  (fire),
      .clr   (flag_clr),
      .flag  (alarm_flag)
   );

   always_comb begin
      alarm_irq = alarm_flag && irq_en;
   end
endmodule

// File: rtl/bcd_alarm_match_chk.sv
module bcd_alarm_match_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        sec_tick,
   input logic        flag_clr,
   input logic        alarm_en,
   input logic        irq_en,
   input logic        wr_allowed,
   input logic [31:0] alarm_word,
   input logic        alarm_flag,
   input logic        alarm_irq
);
   assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_flag && !flag_clr |=> alarm_flag);

   assert_clear_works_R6: assert property (@(posedge clk) disable iff (!rst_n)
      flag_clr && !sec_tick |=> !alarm_flag);

   assert_set_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alarm_flag) |-> $past(sec_tick) && $past(alarm_en));

   assert_irq_needs_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_irq |-> alarm_flag);

   assert_irq_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |-> !alarm_irq);

   assert_locked_when_enabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_en |-> !wr_allowed);

   assert_word_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_allowed |=> $stable(alarm_word));
endmodule

bind bcd_alarm_match bcd_alarm_match_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sec_tick   (sec_tick),
   .flag_clr   (flag_clr),
   .alarm_en   (alarm_en),
   .irq_en     (irq_en),
   .wr_allowed (wr_allowed),
   .alarm_word (alarm_word),
   .alarm_flag (alarm_flag),
   .alarm_irq  (alarm_irq)
);

// File: tb/bcd_alarm_match_tb_top.sv
`timescale 1ns/1ps
module bcd_alarm_match_tb_top;
   localparam int SYNC = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sec_tick = 1'b0;
   logic [6:0]  cal_sec = '0;
   logic [6:0]  cal_min = '0;
   logic [5:0]  cal_hour = '0;
   logic        cal_pm = 1'b0;
   logic [5:0]  cal_date = '0;
   logic [2:0]  cal_wday = '0;
   logic        ctrl_we = 1'b0;
   logic        ctrl_alarm_en = 1'b0;
   logic        ctrl_irq_en = 1'b0;
   logic        word_we = 1'b0;
   logic [31:0] word_wdata = '0;
   logic        flag_clr = 1'b0;
   logic [31:0] alarm_word;
   logic        alarm_en, irq_en, wr_allowed, alarm_flag, alarm_irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   bcd_alarm_match #(.SYNC_CYCLES(SYNC)) dut_i (
      .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
      .cal_sec(cal_sec), .cal_min(cal_min), .cal_hour(cal_hour),
      .cal_pm(cal_pm), .cal_date(cal_date), .cal_wday(cal_wday),
      .ctrl_we(ctrl_we), .ctrl_alarm_en(ctrl_alarm_en), .ctrl_irq_en(ctrl_irq_en),
      .word_we(word_we), .word_wdata(word_wdata), .flag_clr(flag_clr),
      .alarm_word(alarm_word), .alarm_en(alarm_en), .irq_en(irq_en),
      .wr_allowed(wr_allowed), .alarm_flag(alarm_flag), .alarm_irq(alarm_irq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- reference model ----------------
   logic [31:0] m_word;
   bit m_en, m_ien, m_wok, m_flag;
   int m_cnt;

   function automatic bit m_hit(input logic [31:0] w);
      bit ok = 1'b1;
      if (!w[7]  && w[6:0]   != cal_sec)  ok = 1'b0;
      if (!w[15] && w[14:8]  != cal_min)  ok = 1'b0;
      if (!w[23] && (w[21:16] != cal_hour || w[22] != cal_pm)) ok = 1'b0;
      if (!w[31]) begin
         if (w[30]) begin
            if (w[27:24] != {1'b0, cal_wday}) ok = 1'b0;
         end else if (w[29:24] != cal_date) ok = 1'b0;
      end
      return ok;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_word = '0; m_en = 0; m_ien = 0; m_wok = 0; m_flag = 0; m_cnt = 0;
      end else begin
         bit fire;
         bit en_nx;
         fire  = sec_tick && m_en && m_hit(m_word);
         en_nx = ctrl_we ? ctrl_alarm_en : m_en;
         if (word_we && m_wok) m_word = word_wdata;
         if (en_nx) begin
            m_wok = 0; m_cnt = 0;
         end else if (!m_wok) begin
            if (m_cnt == SYNC) m_wok = 1; else m_cnt++;
         end
         if (ctrl_we) begin m_en = ctrl_alarm_en; m_ien = ctrl_irq_en; end
         if (fire) m_flag = 1; else if (flag_clr) m_flag = 0;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R9 model word", alarm_word, m_word);
         chk("R1 model enables", {alarm_en, irq_en}, {m_en, m_ien});
         chk("R8 model wr_allowed", wr_allowed, m_wok);
         chk("R6 model flag", alarm_flag, m_flag);
         chk("R7 model irq", alarm_irq, m_flag && m_ien);
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_ctrl(input bit en, input bit ien);
      ctrl_we = 1; ctrl_alarm_en = en; ctrl_irq_en = ien;
      @(negedge clk);
      ctrl_we = 0;
   endtask

   task automatic put_word(input logic [31:0] w);
      word_we = 1; word_wdata = w;
      @(negedge clk);
      word_we = 0;
   endtask

   task automatic tick();
      sec_tick = 1;
      @(negedge clk);
      sec_tick = 0;
   endtask

   task automatic clear();
      flag_clr = 1;
      @(negedge clk);
      flag_clr = 0;
   endtask

   task automatic set_cal(input logic [6:0] s, input logic [6:0] m, input logic [5:0] h,
                          input bit pm, input logic [5:0] d, input logic [2:0] wd);
      cal_sec = s; cal_min = m; cal_hour = h; cal_pm = pm; cal_date = d; cal_wday = wd;
   endtask

   task automatic load_alarm(input logic [31:0] w, input bit ien);
      set_ctrl(0, ien);
      idle(SYNC + 1);
      put_word(w);
      set_ctrl(1, ien);
   endtask

   function automatic logic [31:0] mk(input bit ddc, input bit wsel, input logic [5:0] day,
                                      input bit hdc, input bit pm, input logic [5:0] hr,
                                      input bit mdc, input logic [6:0] mn,
                                      input bit sdc, input logic [6:0] sc);
      return {ddc, wsel, day, hdc, pm, hr, mdc, mn, sdc, sc};
   endfunction

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] w_basic;
      idle(3);
      chk("R1 word reset", alarm_word, 32'h0);
      chk("R1 flag reset", {alarm_flag, alarm_irq}, 2'b00);
      chk("R1 wr_allowed reset", wr_allowed, 1'b0);
      rst_n = 1;
      idle(SYNC + 2);
      chk("R8 opens after reset", wr_allowed, 1'b1);

      // R2: full match on day of month
      w_basic = mk(0, 0, 6'h12, 0, 0, 6'h09, 0, 7'h15, 0, 7'h30);
      put_word(w_basic);
      set_ctrl(1, 1);
      chk("R8 closes on enable", wr_allowed, 1'b0);
      chk("R2 word stored", alarm_word, w_basic);
      set_cal(7'h30, 7'h15, 6'h09, 0, 6'h12, 3'd2);
      tick();
      chk("R2 full match sets flag", alarm_flag, 1'b1);
      chk("R7 irq with enable", alarm_irq, 1'b1);

      // R10: stays matched, no new tick
      clear();
      idle(3);
      chk("R10 no refire without tick", alarm_flag, 1'b0);
      tick();
      chk("R10 next tick fires again", alarm_flag, 1'b1);
      clear();

      // R2: one field off
      set_cal(7'h31, 7'h15, 6'h09, 0, 6'h12, 3'd2);
      tick();
      chk("R2 seconds mismatch", alarm_flag, 1'b0);
      set_cal(7'h30, 7'h15, 6'h09, 1, 6'h12, 3'd2);
      tick();
      chk("R2 PM mismatch", alarm_flag, 1'b0);

      // R9: write while enabled ignored
      put_word(32'hDEAD_BEEF);
      chk("R9 locked write ignored", alarm_word, w_basic);

      // R8: exact open timing
      set_ctrl(0, 0);
      chk("R8 edge 1 still closed", wr_allowed, 1'b0);
      @(negedge clk);
      chk("R8 edge 2 still closed", wr_allowed, 1'b0);
      @(negedge clk);
      chk("R8 opens at SYNC edges", wr_allowed, 1'b1);

      // R5: tick while disabled
      set_cal(7'h30, 7'h15, 6'h09, 0, 6'h12, 3'd2);
      tick();
      chk("R5 disabled tick ignored", alarm_flag, 1'b0);

      // R3: seconds and minutes masked, irq disabled
      load_alarm(mk(0, 0, 6'h12, 0, 0, 6'h09, 1, 7'h00, 1, 7'h00), 0);
      set_cal(7'h47, 7'h58, 6'h09, 0, 6'h12, 3'd2);
      idle(2);
      chk("R5 no tick no flag", alarm_flag, 1'b0);
      tick();
      chk("R3 masked fields ignored", alarm_flag, 1'b1);
      chk("R7 irq masked", alarm_irq, 1'b0);
      clear();
      set_cal(7'h47, 7'h58, 6'h10, 0, 6'h12, 3'd2);
      tick();
      chk("R3 unmasked hour still compared", alarm_flag, 1'b0);

      // R3: hour mask covers PM too
      load_alarm(mk(0, 0, 6'h12, 1, 1, 6'h23, 0, 7'h00, 0, 7'h05), 1);
      set_cal(7'h05, 7'h00, 6'h07, 0, 6'h12, 3'd2);
      tick();
      chk("R3 hour mask", alarm_flag, 1'b1);
      clear();

      // R4: weekday select, bits 29:28 ignored
      load_alarm(mk(0, 1, 6'h33, 0, 0, 6'h08, 0, 7'h00, 0, 7'h00), 1);
      set_cal(7'h00, 7'h00, 6'h08, 0, 6'h25, 3'd3);
      tick();
      chk("R4 weekday match", alarm_flag, 1'b1);
      clear();
      set_cal(7'h00, 7'h00, 6'h08, 0, 6'h03, 3'd4);
      tick();
      chk("R4 weekday mismatch", alarm_flag, 1'b0);

      // R4: day mask
      load_alarm(mk(1, 0, 6'h01, 0, 0, 6'h08, 0, 7'h00, 0, 7'h00), 1);
      set_cal(7'h00, 7'h00, 6'h08, 0, 6'h29, 3'd6);
      tick();
      chk("R4 day mask any date", alarm_flag, 1'b1);

      // R6: fire and clear together
      flag_clr = 1; sec_tick = 1;
      @(negedge clk);
      flag_clr = 0; sec_tick = 0;
      chk("R6 set beats clear", alarm_flag, 1'b1);
      idle(2);
      chk("R6 sticky", alarm_flag, 1'b1);
      clear();
      chk("R6 cleared", alarm_flag, 1'b0);

      idle(2);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule